// File: doc/BRIEF.md
# Programmable Multi-Mode Delay Timer

This block drives an active-low output from a trigger input. One of four modes sets how the trigger is followed. Delayed operate holds back only the trigger rising edge. Delayed release holds back only the falling edge. Dual delay holds back both edges. One-shot sends out one timed low pulse for each trigger rising edge. In the three level-following modes the output settles at the inverse of the trigger. The mode decides only whether a change is immediate or timed. A second output bit stands in for an open-drain copy and always equals the main output.

Time is measured in time-base half-periods. The `tbTick` strobe is asserted for one system clock every half-period. An 8-bit binary weight W comes from a shared bus through a transparent hold controlled by `loadHold`. A prescale factor S is chosen from three values. A delay lasts 2·S·W+1 half-ticks, which is S·W plus half a time-base period. A one-shot pulse lasts 2·S·W half-ticks. The `timerRst` input aborts any timing and forces the output high. When it is released with the trigger already high, each mode reacts in its own way.

Top module: `delay_timer`

## Requirements
- R1: While `timerRst` is high, the output is high from the next clock on and no timing is pending. The output is high when reset is first released.
- R2: While `loadHold` is low, the weight W used by the timer is the current `weightBus` value. While it is high, W keeps the bus value from the last cycle before it rose. Bus bit i weighs 2^i.
- R3: `scaleSel` encodes S as 0→1, 1→3000, 2→3600, 3→1. With `ALT_SCALE`=1 the codes 1 and 2 give 32768 and 1966080 instead.
- R4: `modeSel`=0 (delayed operate): a trigger rise drives the output low after the (2·S·W+1)-th `tbTick` that follows the edge. A trigger fall drives it high on the next clock.
- R5: `modeSel`=1 (delayed release): a trigger rise drives the output low on the next clock. A trigger fall drives it high after 2·S·W+1 ticks.
- R6: `modeSel`=2 (dual delay): both trigger edges are followed after 2·S·W+1 ticks.
- R7: `modeSel`=3 (one-shot): a trigger rise drives the output low on the next clock for 2·S·W ticks. With W=0 there is no pulse. A rise during a pulse neither extends nor restarts it.
- R8: In the level-following modes, a trigger that returns to its earlier level before a timed change completes cancels that change.
- R9: When reset is released with the trigger high, modes 0 and 2 start a timed fall, mode 1 falls on the next clock, and mode 3 stays high. When it is released with the trigger low, every mode stays high.
- R10: `drainOutN` equals `delayOutN` in every cycle.
- R11: Timing advances only on cycles with `tbTick` high. With W=0 in modes 0 to 2, the delay is a single tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| timerRst | input | 1 | Timer reset, active high, synchronous |
| tbTick | input | 1 | Strobe once per time-base half-period |
| trigIn | input | 1 | Trigger level |
| loadHold | input | 1 | High holds the weight, low lets it follow the bus |
| weightBus | input | 8 | Binary-weighted delay value |
| modeSel | input | 2 | 0 operate, 1 release, 2 dual, 3 one-shot |
| scaleSel | input | 2 | Prescale code |
| delayOutN | output | 1 | Active-low delayed output |
| drainOutN | output | 1 | Copy of the output for the open-drain stage |

## Verification
The hardest states to reach are the races. One is a trigger edge that lands while a timed change is still counting. Another is a reset release that meets a trigger already high in each mode. Directed sequences place these edges a fixed number of clocks into a running count. Other sequences hold the trigger high across reset in all four modes. Long random runs with sparse `tbTick`, small weights and rare trigger toggles then produce many mid-count edges. A bench model checks every cycle of these runs.

// File: rtl/delay_timer_pkg.sv
package delay_timer_pkg;

  typedef enum logic [1:0] {
    MODE_OPERATE = 2'd0,
    MODE_RELEASE = 2'd1,
    MODE_DUAL    = 2'd2,
    MODE_ONESHOT = 2'd3
  } tmrMode_t;

  // control to datapath strobes
  typedef struct packed {
    logic loadDelay;  // load 2*S*W+1
    logic loadPulse;  // load 2*S*W
    logic decr;       // count one half-tick
  } tmrStrobe_t;

  function automatic int unsigned scaleFactor(input logic alt, input logic [1:0] sel);
    case (sel)
      2'd1:    return alt ? 32'd32768   : 32'd3000;
      2'd2:    return alt ? 32'd1966080 : 32'd3600;
      default: return 32'd1;
    endcase
  endfunction

endpackage

// File: rtl/delay_timer_dp.sv
module delay_timer_dp
  import delay_timer_pkg::*;
#(
  parameter bit ALT_SCALE = 1'b0,
  parameter int WEIGHT_W  = 8,
  parameter int CNT_W     = 24
) (
  input  logic                clk,
  input  logic                loadHold,
  input  logic [WEIGHT_W-1:0] weightBus,
  input  logic [1:0]          scaleSel,
  input  tmrStrobe_t          strobe,
  output logic                cntIsOne,
  output logic                weightZero
);

  logic [WEIGHT_W-1:0] heldW;
  logic [WEIGHT_W-1:0] weightEff;
  logic [CNT_W-1:0]    cnt;
  int unsigned         scale;
  int unsigned         span;

  // transparent hold: follow the bus while loadHold is low
  always_ff @(posedge clk) begin
    if (!loadHold) heldW <= weightBus;
  end

  always_comb begin
    weightEff = loadHold ? heldW : weightBus;
    scale     = scaleFactor(ALT_SCALE, scaleSel);
    span      = 32'd2 * scale * 32'(weightEff);
  end

  assign weightZero = (weightEff == '0);
  assign cntIsOne   = (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (strobe.loadDelay)      cnt <= CNT_W'(span + 32'd1);
    else if (strobe.loadPulse) cnt <= CNT_W'(span);
    else if (strobe.decr)      cnt <= cnt - CNT_W'(1);
  end

endmodule

// File: rtl/delay_timer_ctrl.sv
module delay_timer_ctrl
  import delay_timer_pkg::*;
(
  input  logic       clk,
  input  logic       timerRst,
  input  logic       tbTick,
  input  logic       trigIn,
  input  logic [1:0] modeSel,
  input  logic       cntIsOne,
  input  logic       weightZero,
  output tmrStrobe_t strobe,
  output logic       outQ
);

  tmrMode_t mode;
  logic trigPrev, rstPrev, pending;
  logic outNext, pendNext;
  logic trigRise, trigFall, relEvt, levelEvt, desired, delayEdge;

  assign mode = tmrMode_t'(modeSel);

  always_comb begin
    trigRise  = trigIn & ~trigPrev;
    trigFall  = ~trigIn & trigPrev;
    relEvt    = rstPrev & ~timerRst;
    levelEvt  = trigRise | trigFall | (relEvt & trigIn);
    desired   = ~trigIn;
    delayEdge = trigIn ? (mode == MODE_OPERATE || mode == MODE_DUAL)
                       : (mode == MODE_RELEASE || mode == MODE_DUAL);
    outNext   = outQ;
    pendNext  = pending;
    strobe    = '0;
    if (timerRst) begin
      outNext  = 1'b1;
      pendNext = 1'b0;
    end else if (mode == MODE_ONESHOT) begin
      if (trigRise && !pending) begin
        if (!weightZero) begin
          outNext          = 1'b0;
          pendNext         = 1'b1;
          strobe.loadPulse = 1'b1;
        end
      end else if (pending && tbTick) begin
        if (cntIsOne) begin
          outNext  = 1'b1;
          pendNext = 1'b0;
        end else begin
          strobe.decr = 1'b1;
        end
      end
    end else if (levelEvt) begin
      if (outQ == desired) begin
        pendNext = 1'b0;
      end else if (delayEdge) begin
        pendNext         = 1'b1;
        strobe.loadDelay = 1'b1;
      end else begin
        outNext  = desired;
        pendNext = 1'b0;
      end
    end else if (pending && tbTick) begin
      if (cntIsOne) begin
        outNext  = ~outQ;
        pendNext = 1'b0;
      end else begin
        strobe.decr = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    trigPrev <= trigIn;
    rstPrev  <= timerRst;
    outQ     <= outNext;
    pending  <= pendNext;
  end

endmodule

// File: rtl/delay_timer.sv
module delay_timer
  import delay_timer_pkg::*;
#(
  parameter bit ALT_SCALE = 1'b0,
  parameter int WEIGHT_W  = 8
) (
  input  logic                clk,
  input  logic                timerRst,
  input  logic                tbTick,
  input  logic                trigIn,
  input  logic                loadHold,
  input  logic [WEIGHT_W-1:0] weightBus,
  input  logic [1:0]          modeSel,
  input  logic [1:0]          scaleSel,
  output logic                delayOutN,
  output logic                drainOutN
);

  localparam longint MAX_SCALE = ALT_SCALE ? 64'd1966080 : 64'd3600;
  localparam longint MAX_SPAN  = 64'd2 * MAX_SCALE * ((64'd1 << WEIGHT_W) - 64'd1) + 64'd2;
  localparam int     CNT_W     = $clog2(MAX_SPAN);

  tmrStrobe_t strobe;
  logic cntIsOne, weightZero, outQ;

  delay_timer_ctrl u_ctrl (
    .clk(clk), .timerRst(timerRst), .tbTick(tbTick), .trigIn(trigIn),
    .modeSel(modeSel), .cntIsOne(cntIsOne), .weightZero(weightZero),
    .strobe(strobe), .outQ(outQ)
  );

  delay_timer_dp #(.ALT_SCALE(ALT_SCALE), .WEIGHT_W(WEIGHT_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .loadHold(loadHold), .weightBus(weightBus), .scaleSel(scaleSel),
    .strobe(strobe), .cntIsOne(cntIsOne), .weightZero(weightZero)
  );

  assign delayOutN = outQ;
  assign drainOutN = outQ;

endmodule

// File: rtl/delay_timer_chk.sv
module delay_timer_chk (
  input logic       clk,
  input logic       timerRst,
  input logic       trigIn,
  input logic [1:0] modeSel,
  input logic       delayOutN
);

  // R1
  rst_release_high_chk: assert property (@(posedge clk) disable iff (timerRst)
    $fell(timerRst) |-> delayOutN);

  // R4
  operate_fall_now_chk: assert property (@(posedge clk) disable iff (timerRst)
    (modeSel == 2'd0 && $past(modeSel) == 2'd0 && $fell(trigIn)) |=> delayOutN);

  // R4
  operate_low_needs_trig_chk: assert property (@(posedge clk) disable iff (timerRst)
    (modeSel == 2'd0 && $past(modeSel) == 2'd0 && $fell(delayOutN)) |-> $past(trigIn));

  // R5
  release_rise_now_chk: assert property (@(posedge clk) disable iff (timerRst)
    (modeSel == 2'd1 && $past(modeSel) == 2'd1 && $rose(trigIn)) |=> !delayOutN);

  // R7
  oneshot_start_on_rise_chk: assert property (@(posedge clk) disable iff (timerRst)
    (modeSel == 2'd3 && $past(modeSel) == 2'd3 && $fell(delayOutN))
      |-> ($past(trigIn) && !$past(trigIn, 2)));

endmodule

bind delay_timer delay_timer_chk u_chk (.*);

// File: tb/tb_delay_timer.sv
module tb_delay_timer;

  logic clk = 1'b0;
  logic timerRst = 1'b1, tbTick = 1'b1, trigIn = 1'b0, loadHold = 1'b0;
  logic [7:0] weightBus = 8'd0;
  logic [1:0] modeSel = 2'd0, scaleSel = 2'd0;
  logic delayOutN, drainOutN;
  int checks = 0, errors = 0, cyc = 0;
  bit cmpOn = 1'b0;

  always #5 clk = ~clk;

  delay_timer dut (.*);

  // bench model built from the requirements
  logic mOut, mTrigP, mRstP;
  logic [7:0] mHeld;
  int mLeft;

  function automatic int scaleOf(input logic [1:0] s);
    if (s == 2'd1) return 3000;
    if (s == 2'd2) return 3600;
    return 1;
  endfunction

  function automatic bit isTimed(input logic [1:0] m, input logic level);
    if (m == 2'd2) return 1'b1;
    return level ? (m == 2'd0) : (m == 2'd1);
  endfunction

  always @(posedge clk) begin
    automatic logic [7:0] w = loadHold ? mHeld : weightBus;
    automatic int span = 2 * scaleOf(scaleSel) * int'(w);
    mTrigP <= trigIn;
    mRstP  <= timerRst;
    if (!loadHold) mHeld <= weightBus;
    if (timerRst) begin
      mOut <= 1'b1; mLeft <= 0;
    end else if (modeSel == 2'd3) begin
      if (trigIn && !mTrigP && mLeft == 0) begin
        if (span != 0) begin mOut <= 1'b0; mLeft <= span; end
      end else if (mLeft != 0 && tbTick) begin
        if (mLeft == 1) mOut <= 1'b1;
        mLeft <= mLeft - 1;
      end
    end else if (trigIn != mTrigP || (mRstP && trigIn)) begin
      if (mOut == !trigIn) mLeft <= 0;
      else if (isTimed(modeSel, trigIn)) mLeft <= span + 1;
      else begin mOut <= !trigIn; mLeft <= 0; end
    end else if (mLeft != 0 && tbTick) begin
      if (mLeft == 1) mOut <= !mOut;
      mLeft <= mLeft - 1;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count clock edges until the output level changes
  task automatic measure(input string req, input int exp);
    automatic logic lvl = delayOutN;
    automatic int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (delayOutN == lvl && k < 10000);
    chk(req, k, exp);
  endtask

  task automatic restart(input logic [1:0] m, input logic [7:0] w, input logic [1:0] s, input logic trig);
    timerRst = 1'b1; trigIn = trig; modeSel = m; weightBus = w; scaleSel = s;
    loadHold = 1'b0; tbTick = 1'b1;
    cycles(3);
  endtask

  task automatic start(input logic [1:0] m, input logic [7:0] w, input logic [1:0] s);
    restart(m, w, s, 1'b0);
    timerRst = 1'b0;
    cycles(2);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cmpOn) begin
      chk("R4-R9 model", delayOutN, mOut);
      chk("R10 drain copy", drainOutN, delayOutN);
    end
  end

  initial begin
    automatic int unused = $urandom(32'd2024);
    @(negedge clk);
    cycles(3);
    // R1: reset state
    chk("R1 reset out", delayOutN, 1);
    chk("R10 reset drain", drainOutN, 1);

    // R4: W=3 gives 7 ticks
    start(2'd0, 8'd3, 2'd0);
    trigIn = 1'b1; measure("R4 operate rise", 8);
    trigIn = 1'b0; measure("R4 operate fall", 1);
    // R5
    start(2'd1, 8'd3, 2'd0);
    trigIn = 1'b1; measure("R5 release rise", 1);
    trigIn = 1'b0; measure("R5 release fall", 8);
    // R6
    start(2'd2, 8'd3, 2'd0);
    trigIn = 1'b1; measure("R6 dual rise", 8);
    trigIn = 1'b0; measure("R6 dual fall", 8);
    // R11: W=0 gives one tick
    start(2'd0, 8'd0, 2'd0);
    trigIn = 1'b1; measure("R11 zero weight", 2);
    // R7: pulse of 6 ticks
    start(2'd3, 8'd3, 2'd0);
    trigIn = 1'b1; measure("R7 pulse start", 1);
    measure("R7 pulse width", 6);
    trigIn = 1'b0; cycles(2);
    // R7: retrigger ignored
    trigIn = 1'b1; measure("R7 retrig start", 1);
    trigIn = 1'b0; cycles(1);
    trigIn = 1'b1; cycles(1);
    measure("R7 retrig ignored", 4);
    trigIn = 1'b0; cycles(2);
    // R7: W=0 no pulse
    start(2'd3, 8'd0, 2'd0);
    trigIn = 1'b1; cycles(10);
    chk("R7 zero weight no pulse", delayOutN, 1);
    // R8: cancel before timeout (11 ticks)
    start(2'd0, 8'd5, 2'd0);
    trigIn = 1'b1; cycles(4);
    trigIn = 1'b0; cycles(20);
    chk("R8 cancel operate", delayOutN, 1);
    start(2'd2, 8'd5, 2'd0);
    trigIn = 1'b1; measure("R8 dual low", 12);
    trigIn = 1'b0; cycles(3);
    trigIn = 1'b1; cycles(20);
    chk("R8 cancel dual", delayOutN, 0);
    // R1: reset aborts pending
    trigIn = 1'b0; cycles(2);
    timerRst = 1'b1; cycles(1);
    chk("R1 abort", delayOutN, 1);
    // R11: no ticks, no progress
    start(2'd0, 8'd1, 2'd0);
    tbTick = 1'b0; trigIn = 1'b1; cycles(20);
    chk("R11 no tick hold", delayOutN, 1);
    tbTick = 1'b1; measure("R11 tick resume", 3);
    // R2: weight held while loadHold high
    start(2'd0, 8'd2, 2'd0);
    loadHold = 1'b1; cycles(1);
    weightBus = 8'd9; cycles(1);
    trigIn = 1'b1; measure("R2 held weight", 6);
    trigIn = 1'b0; cycles(2);
    loadHold = 1'b0; cycles(1);
    trigIn = 1'b1; measure("R2 follow bus", 20);
    // R3: prescale codes
    start(2'd0, 8'd1, 2'd1);
    trigIn = 1'b1; measure("R3 scale 3000", 6002);
    start(2'd0, 8'd1, 2'd2);
    trigIn = 1'b1; measure("R3 scale 3600", 7202);
    start(2'd0, 8'd1, 2'd3);
    trigIn = 1'b1; measure("R3 scale code3", 4);
    // R9: reset release with trigger high
    restart(2'd0, 8'd1, 2'd0, 1'b1);
    timerRst = 1'b0; measure("R9 operate release", 4);
    restart(2'd2, 8'd1, 2'd0, 1'b1);
    timerRst = 1'b0; measure("R9 dual release", 4);
    restart(2'd1, 8'd1, 2'd0, 1'b1);
    timerRst = 1'b0; measure("R9 release mode", 1);
    restart(2'd3, 8'd1, 2'd0, 1'b1);
    timerRst = 1'b0; cycles(10);
    chk("R9 oneshot stays high", delayOutN, 1);
    restart(2'd1, 8'd1, 2'd0, 1'b0);
    timerRst = 1'b0; cycles(10);
    chk("R9 trig low stays high", delayOutN, 1);

    // random phase compared with the model (R4-R10)
    for (int seg = 0; seg < 10; seg++) begin
      restart(2'($urandom % 4), 8'($urandom % 4), 2'd0, 1'($urandom % 2));
      cmpOn = 1'b1;
      timerRst = 1'b0;
      for (int c = 0; c < 2000; c++) begin
        @(negedge clk);
        if ($urandom % 12 == 0) trigIn = ~trigIn;
        tbTick = 1'($urandom % 2);
        if ($urandom % 40 == 0) loadHold = ~loadHold;
        weightBus = 8'($urandom % 4);
        timerRst = ($urandom % 600 == 0);
      end
      cmpOn = 1'b0;
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule